// File: doc/BRIEF.md
# Multichannel reciprocal frequency counter

This block is a bank of per-channel counters for frequency measurement and event counting. It works on a vector of logic inputs that are already synchronized to the system clock. Every channel has its own pair of counters, and all channels count at the same time. For each channel the block produces an input edge count and a reference-cycle count, together with an overflow flag and a one-cycle result strobe. Host software divides the two counts to get a frequency. The block does not perform that division.

A measurement starts when `arm_i` is pulsed. The mode and gate-time selections are taken at that moment. In direct mode every channel counts rising edges inside one common gate of fixed length. Event mode works the same way, except that an edge is counted only while an optional pattern holds on the lowest eight channels. In reciprocal mode each channel opens its own gate on its first input edge and closes it on the first input edge that arrives once the gate time has run. The reference cycles between those two edges are counted, so the resolution does not depend on the input frequency. The gate times stand for 100 ms, 1 s, 10 s and infinite. They are derived from the reference clock frequency parameter and can be shortened by a scale parameter.

Top module: `freq_counter_bank`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, all edge and reference results read zero and every strobe and overflow bit is low.
- R2: An edge is a 0 to 1 change of a channel between two consecutive clocks, and each such edge adds exactly one to that channel's edge count. An input that stays high or falls adds nothing.
- R3: Direct mode is `mode_i`=1; code 3 behaves the same way. With `gate_sel_i` = 0, 1 or 2, the gate length T is REF_HZ/10/TIME_SCALE, REF_HZ/TIME_SCALE or 10*REF_HZ/TIME_SCALE cycles respectively. The gate covers the T clocks that follow the arming clock. Each channel reports the edges seen in those clocks, with a reference count of T. The strobe rises on the clock that ends the T-th gate cycle.
- R4: Selection `gate_sel_i`=3 means an infinite gate. In direct or event mode this gate closes only on a `stop_i` pulse. The reference count then equals the number of gate clocks, including the clock that carries the stop, and edges in the stop clock are counted.
- R5: Event mode is `mode_i`=0. When `pat_en_i` is 1, an edge is counted only if `((din_i[7:0] ^ pat_val_i) & pat_mask_i) == 0` in the same clock. Mask bits at or above the channel count are ignored. When `pat_en_i` is 0, every edge is counted.
- R6: Reciprocal mode is `mode_i`=2. After arming, a channel waits for its first edge, which opens its gate. The gate closes on the first later edge whose distance in clocks from the opening edge is at least T. The reported reference count is that distance, and the reported edge count is the number of edges after the opening edge, up to and including the closing edge.
- R7: In reciprocal mode with any gate selection, a `stop_i` pulse makes every channel close on its next edge, including an edge in the stop clock itself. A channel that has not opened yet opens on its next edge and closes on the edge after that.
- R8: A count that would pass its maximum of 2^CNT_W-1 stays at the maximum. The channel's overflow bit is then set in the result.
- R9: A pulse on `arm_i` restarts all channels and discards any measurement in progress. No strobe occurs in the clock after arming. Results and overflow bits hold their last values until that channel's next strobe.
- R10: In direct and event modes all channels strobe in the same clock. In reciprocal mode each channel strobes on its own, when its own gate closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (system) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din_i | input | N_CH | Synchronized logic inputs, one bit per channel |
| arm_i | input | 1 | Start pulse; takes the mode and gate selection |
| stop_i | input | 1 | Stop pulse for infinite gates or early reciprocal close |
| mode_i | input | 2 | 0 event, 1 direct, 2 reciprocal, 3 treated as direct |
| gate_sel_i | input | 2 | 0 short, 1 medium, 2 long, 3 infinite |
| pat_en_i | input | 1 | Enables pattern qualification in event mode |
| pat_val_i | input | 8 | Required levels of the low eight channels |
| pat_mask_i | input | 8 | Which of the low eight channels take part in the match |
| edge_cnt_o | output | N_CH*CNT_W | Per-channel edge count results, channel 0 in the low bits |
| ref_cnt_o | output | N_CH*CNT_W | Per-channel reference-cycle count results |
| valid_o | output | N_CH | Per-channel one-clock result strobe |
| ovf_o | output | N_CH | Per-channel overflow bit of the last result |

## Verification
The bench builds the block with ten channels and 10-bit counters, so both the pattern byte and channels above it are exercised and saturation is reached after 1023 edges. REF_HZ is 1000 and TIME_SCALE is 10, which makes the three timed gates 10, 100 and 1000 clocks long. All three gates can then be run to completion, and a counter can be driven into overflow within a few thousand clocks. Reciprocal runs use square waves of different periods on each channel, so the channels open and close in different clocks.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  typedef enum logic [1:0] {
    M_EVENT  = 2'd0,
    M_DIRECT = 2'd1,
    M_RECIP  = 2'd2,
    M_RSVD   = 2'd3
  } cnt_mode_e;

  localparam int PAT_W = 8;

  // Gate length in reference cycles; zero stands for an endless gate.
  function automatic logic [63:0] gate_ticks(input logic [1:0] sel,
                                             input longint unsigned ref_hz,
                                             input longint unsigned scale);
    case (sel)
      2'd0:    return 64'(ref_hz / 64'd10 / scale);
      2'd1:    return 64'(ref_hz / scale);
      2'd2:    return 64'((ref_hz * 64'd10) / scale);
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic pattern_hit(input logic [PAT_W-1:0] bits,
                                       input logic [PAT_W-1:0] want,
                                       input logic [PAT_W-1:0] care);
    return ((bits ^ want) & care) == '0;
  endfunction

endpackage

// File: rtl/fcb_edge.sv
module fcb_edge #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= din;
  end

  assign rise = din & ~prev;
endmodule

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import fcb_pkg::*;
#(
  parameter longint unsigned REF_HZ     = 100_000_000,
  parameter int unsigned     TIME_SCALE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm_i,
  input  logic        stop_i,
  input  logic [1:0]  mode_i,
  input  logic [1:0]  gate_sel_i,
  output cnt_mode_e   mode_q,
  output logic [63:0] ticks_q,
  output logic        gate_open,
  output logic        gate_close,
  output logic        stop_req
);
  localparam logic [63:0] LONGEST = gate_ticks(2'd2, REF_HZ, 64'(TIME_SCALE));
  localparam int TMR_W = (LONGEST < 64'd2) ? 1 : $clog2(LONGEST + 64'd1);

  logic [TMR_W-1:0] tmr;
  logic [63:0]      tmr_nx;
  logic             time_up;

  assign tmr_nx     = 64'(tmr) + 64'd1;
  assign time_up    = (ticks_q != 64'd0) && (tmr_nx == ticks_q);
  assign gate_close = gate_open && !arm_i && (stop_i || time_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_EVENT;
      ticks_q   <= '0;
      gate_open <= 1'b0;
      tmr       <= '0;
      stop_req  <= 1'b0;
    end else if (arm_i) begin
      mode_q    <= cnt_mode_e'(mode_i);
      ticks_q   <= gate_ticks(gate_sel_i, REF_HZ, 64'(TIME_SCALE));
      gate_open <= (cnt_mode_e'(mode_i) != M_RECIP);
      tmr       <= '0;
      stop_req  <= 1'b0;
    end else begin
      if (stop_i) stop_req <= 1'b1;
      if (gate_close)                  gate_open <= 1'b0;
      else if (gate_open && tmr != '1) tmr       <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/fcb_lane.sv
module fcb_lane
  import fcb_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             arm_recip_i,
  input  cnt_mode_e        mode_q,
  input  logic [63:0]      ticks_q,
  input  logic             gate_close,
  input  logic             stop_any,
  input  logic             rise,
  input  logic             qual,
  output logic [CNT_W-1:0] edge_res,
  output logic [CNT_W-1:0] ref_res,
  output logic             ovf_res,
  output logic             valid_res
);
  typedef enum logic [1:0] {L_IDLE, L_WAIT, L_OPEN} lane_st_e;
  localparam logic [CNT_W-1:0] CMAX = '1;

  // Returns {overflow, next value}; the value sticks at the maximum.
  function automatic logic [CNT_W:0] sat_add1(input logic [CNT_W-1:0] v, input logic inc);
    if (!inc)       return {1'b0, v};
    if (v == CMAX)  return {1'b1, v};
    return {1'b0, v + CNT_W'(1)};
  endfunction

  lane_st_e         st;
  logic [CNT_W-1:0] ecnt, rcnt, e_nx, r_nx;
  logic             e_ov, r_ov, ovf_flag, ovf_nx;
  logic             count_inc, time_up, rec_close, glob_close, close_now;

  assign count_inc       = rise && ((mode_q != M_EVENT) || qual);
  assign {e_ov, e_nx}    = sat_add1(ecnt, count_inc);
  assign {r_ov, r_nx}    = sat_add1(rcnt, 1'b1);
  assign ovf_nx          = ovf_flag | e_ov | r_ov;
  assign time_up         = (ticks_q != 64'd0) && ((64'(r_nx) >= ticks_q) || (r_nx == CMAX));
  assign rec_close       = (st == L_OPEN) && (mode_q == M_RECIP) && rise && (stop_any || time_up);
  assign glob_close      = (st == L_OPEN) && (mode_q != M_RECIP) && gate_close;
  assign close_now       = rec_close || glob_close;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= L_IDLE;
      ecnt      <= '0;
      rcnt      <= '0;
      ovf_flag  <= 1'b0;
      edge_res  <= '0;
      ref_res   <= '0;
      ovf_res   <= 1'b0;
      valid_res <= 1'b0;
    end else begin
      valid_res <= 1'b0;
      if (arm_i) begin
        st       <= arm_recip_i ? L_WAIT : L_OPEN;
        ecnt     <= '0;
        rcnt     <= '0;
        ovf_flag <= 1'b0;
      end else begin
        case (st)
          L_WAIT: if (rise) begin
            st       <= L_OPEN;
            ecnt     <= '0;
            rcnt     <= '0;
            ovf_flag <= 1'b0;
          end
          L_OPEN: if (close_now) begin
            edge_res  <= e_nx;
            ref_res   <= r_nx;
            ovf_res   <= ovf_nx;
            valid_res <= 1'b1;
            st        <= L_IDLE;
          end else begin
            ecnt     <= e_nx;
            rcnt     <= r_nx;
            ovf_flag <= ovf_nx;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/freq_counter_bank.sv
module freq_counter_bank
  import fcb_pkg::*;
#(
  parameter int              N_CH       = 18,
  parameter int              CNT_W      = 64,
  parameter longint unsigned REF_HZ     = 100_000_000,
  parameter int unsigned     TIME_SCALE = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       din_i,
  input  logic                  arm_i,
  input  logic                  stop_i,
  input  logic [1:0]            mode_i,
  input  logic [1:0]            gate_sel_i,
  input  logic                  pat_en_i,
  input  logic [7:0]            pat_val_i,
  input  logic [7:0]            pat_mask_i,
  output logic [N_CH*CNT_W-1:0] edge_cnt_o,
  output logic [N_CH*CNT_W-1:0] ref_cnt_o,
  output logic [N_CH-1:0]       valid_o,
  output logic [N_CH-1:0]       ovf_o
);
  localparam int          PW       = (N_CH < PAT_W) ? N_CH : PAT_W;
  localparam logic [7:0]  LOW_MASK = 8'((16'd1 << PW) - 16'd1);

  // Named internal events, observed by the bound checker.
  logic [N_CH-1:0] rise_w;
  cnt_mode_e       mode_q_w;
  logic [63:0]     ticks_w;
  logic            gate_open_w, gate_close_w, stop_req_w, stop_any_w;
  logic            arm_recip_w, qual_w;
  logic [7:0]      pat_bits;

  always_comb begin
    pat_bits         = '0;
    pat_bits[PW-1:0] = din_i[PW-1:0];
  end

  assign qual_w      = !pat_en_i || pattern_hit(pat_bits, pat_val_i, pat_mask_i & LOW_MASK);
  assign arm_recip_w = arm_i && (cnt_mode_e'(mode_i) == M_RECIP);
  assign stop_any_w  = stop_req_w || stop_i;

  fcb_edge #(.W(N_CH)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din_i),
    .rise (rise_w)
  );

  fcb_ctrl #(.REF_HZ(REF_HZ), .TIME_SCALE(TIME_SCALE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm_i),
    .stop_i    (stop_i),
    .mode_i    (mode_i),
    .gate_sel_i(gate_sel_i),
    .mode_q    (mode_q_w),
    .ticks_q   (ticks_w),
    .gate_open (gate_open_w),
    .gate_close(gate_close_w),
    .stop_req  (stop_req_w)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    fcb_lane #(.CNT_W(CNT_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_i      (arm_i),
      .arm_recip_i(arm_recip_w),
      .mode_q     (mode_q_w),
      .ticks_q    (ticks_w),
      .gate_close (gate_close_w),
      .stop_any   (stop_any_w),
      .rise       (rise_w[g]),
      .qual       (qual_w),
      .edge_res   (edge_cnt_o[g*CNT_W +: CNT_W]),
      .ref_res    (ref_cnt_o[g*CNT_W +: CNT_W]),
      .ovf_res    (ovf_o[g]),
      .valid_res  (valid_o[g])
    );
  end
endmodule

// File: rtl/fcb_checks.sv
module fcb_checks #(
  parameter int N_CH  = 18,
  parameter int CNT_W = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  arm_i,
  input logic [1:0]            mode_q,
  input logic                  gate_close,
  input logic [N_CH*CNT_W-1:0] edge_cnt_o,
  input logic [N_CH*CNT_W-1:0] ref_cnt_o,
  input logic [N_CH-1:0]       valid_o,
  input logic [N_CH-1:0]       ovf_o
);
  a_r9_arm_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> valid_o == '0);

  a_r10_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o != '0 && mode_q != 2'd2) |-> valid_o == '1);

  a_r3_valid_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_close && mode_q != 2'd2) |=> valid_o == '1);

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o[i] |-> ($stable(edge_cnt_o[i*CNT_W +: CNT_W]) &&
                       $stable(ref_cnt_o[i*CNT_W +: CNT_W]) && $stable(ovf_o[i])));

    a_r8_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o[i] |-> (edge_cnt_o[i*CNT_W +: CNT_W] == '1 || ref_cnt_o[i*CNT_W +: CNT_W] == '1));
  end
endmodule

bind freq_counter_bank fcb_checks #(.N_CH(N_CH), .CNT_W(CNT_W)) u_fcb_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm_i     (arm_i),
  .mode_q    (mode_q_w),
  .gate_close(gate_close_w),
  .edge_cnt_o(edge_cnt_o),
  .ref_cnt_o (ref_cnt_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o)
);

// File: tb/test_freq_counter_bank.sv
`timescale 1ns/1ps
module test_freq_counter_bank;
  localparam int              N    = 10;
  localparam int              W    = 10;
  localparam longint unsigned RHZ  = 1000;
  localparam int unsigned     SC   = 10;
  localparam int              MAXV = (1 << W) - 1;

  logic           clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]   din = '0;
  logic           arm = 1'b0, stop = 1'b0, pat_en = 1'b0;
  logic [1:0]     mode = 2'd1, gsel = 2'd0;
  logic [7:0]     pat_val = '0, pat_mask = '0;
  logic [N*W-1:0] edge_o, ref_o;
  logic [N-1:0]   valid_o, ovf_o;

  always #2.5 clk = ~clk;

  freq_counter_bank #(.N_CH(N), .CNT_W(W), .REF_HZ(RHZ), .TIME_SCALE(SC)) i_freq_counter_bank (
    .clk(clk), .rst_n(rst_n), .din_i(din), .arm_i(arm), .stop_i(stop),
    .mode_i(mode), .gate_sel_i(gsel), .pat_en_i(pat_en), .pat_val_i(pat_val),
    .pat_mask_i(pat_mask), .edge_cnt_o(edge_o), .ref_cnt_o(ref_o),
    .valid_o(valid_o), .ovf_o(ovf_o)
  );

  typedef struct {
    int    ch;
    int    edges;
    int    refc;
    bit    ovf;
    string req;
  } exp_t;

  exp_t         sb[$];
  int           n_cmp = 0, n_bad = 0;
  logic [N-1:0] prev_v = '0;
  int           last_e[N];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops expectations as strobes appear, lowest channel first.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (valid_o[i]) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R9", $sformatf("unexpected strobe ch%0d", i), 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.ch == i, "R10", "strobe channel", i, e.ch);
            chk(int'(edge_o[i*W +: W]) == e.edges, e.req, $sformatf("edges ch%0d", i),
                edge_o[i*W +: W], e.edges);
            chk(int'(ref_o[i*W +: W]) == e.refc, e.req, $sformatf("ref ch%0d", i),
                ref_o[i*W +: W], e.refc);
            chk(ovf_o[i] == e.ovf, e.req, $sformatf("ovf ch%0d", i), ovf_o[i], e.ovf);
            last_e[i] = e.edges;
          end
        end
      end
    end
  end

  task automatic tick(input logic [N-1:0] v, input logic a, input logic s,
                      output logic [N-1:0] r);
    @(negedge clk);
    din  = v;
    arm  = a;
    stop = s;
    r      = v & ~prev_v;
    prev_v = v;
  endtask

  task automatic idle(input int n);
    logic [N-1:0] r;
    for (int k = 0; k < n; k++) tick(prev_v, 1'b0, 1'b0, r);
  endtask

  function automatic logic [N-1:0] wave(input int k, input int base);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      int per;
      per  = base + i;
      v[i] = (k % per) < (per / 2);
    end
    return v;
  endfunction

  function automatic bit pat_ok(input logic [N-1:0] v);
    return !pat_en || (((v[7:0] ^ pat_val) & pat_mask) == 8'h00);
  endfunction

  function automatic exp_t mk(input int ch, input int ec, input int rc, input string req);
    exp_t e;
    e.ch    = ch;
    e.edges = (ec > MAXV) ? MAXV : ec;
    e.refc  = (rc > MAXV) ? MAXV : rc;
    e.ovf   = (ec > MAXV) || (rc > MAXV);
    e.req   = req;
    return e;
  endfunction

  // Common-gate run: len gate clocks, closed by the timer or by stop in the last clock.
  task automatic run_gated(input logic [1:0] md, input logic [1:0] sel, input int len,
                           input bit use_stop, input int base, input logic [N-1:0] hold_hi,
                           input string req);
    logic [N-1:0] r, v;
    int cnt[N];
    for (int i = 0; i < N; i++) cnt[i] = 0;
    mode = md;
    gsel = sel;
    tick(prev_v, 1'b1, 1'b0, r);
    for (int k = 1; k <= len; k++) begin
      v = wave(k, base) | hold_hi;
      tick(v, 1'b0, use_stop && (k == len), r);
      for (int i = 0; i < N; i++)
        if (r[i] && (md != 2'd0 || pat_ok(v))) cnt[i]++;
    end
    for (int i = 0; i < N; i++) sb.push_back(mk(i, cnt[i], len, req));
    idle(3);
  endtask

  // Reciprocal run: each channel opens on its first edge, closes per R6/R7.
  task automatic run_recip(input logic [1:0] sel, input int tgate, input int len,
                           input int stop_at, input int base, input string req);
    logic [N-1:0] r, v;
    int st[N], k0[N], ec[N];
    bit stopped;
    stopped = 1'b0;
    for (int i = 0; i < N; i++) begin st[i] = 0; k0[i] = 0; ec[i] = 0; end
    mode = 2'd2;
    gsel = sel;
    tick(prev_v, 1'b1, 1'b0, r);
    for (int k = 1; k <= len; k++) begin
      v = wave(k, base);
      tick(v, 1'b0, k == stop_at, r);
      if (stop_at > 0 && k >= stop_at) stopped = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (r[i]) begin
          if (st[i] == 0) begin
            st[i] = 1; k0[i] = k; ec[i] = 0;
          end else if (st[i] == 1) begin
            ec[i]++;
            if (stopped || (tgate != 0 && (k - k0[i]) >= tgate)) begin
              sb.push_back(mk(i, ec[i], k - k0[i], req));
              st[i] = 2;
            end
          end
        end
      end
    end
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) last_e[i] = 0;
    tick('0, 1'b0, 1'b0, r);
    tick('0, 1'b0, 1'b0, r);
    chk(valid_o == '0 && ovf_o == '0, "R1", "strobes in reset", {valid_o, ovf_o}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(edge_o == '0, "R1", "edge results after reset", edge_o, 0);
    chk(ref_o == '0, "R1", "ref results after reset", ref_o, 0);
    chk(valid_o == '0, "R1", "strobes after reset", valid_o, 0);
    chk(ovf_o == '0, "R1", "overflow after reset", ovf_o, 0);

    // R3 short gate; R2 the top channel held high adds nothing
    prev_v[N-1] = 1'b1;
    tick(prev_v, 1'b0, 1'b0, r);
    run_gated(2'd1, 2'd0, 10, 1'b0, 2, 10'h200, "R3");
    // R3 medium gate, reserved mode code behaves as direct
    run_gated(2'd3, 2'd1, 100, 1'b0, 3, '0, "R3");
    // R5 event mode with pattern on ch2=1, ch3=0, long gate
    pat_en = 1'b1; pat_val = 8'h04; pat_mask = 8'h0C;
    run_gated(2'd0, 2'd2, 1000, 1'b0, 2, '0, "R5");
    // R5 mask bits only above the pattern still qualify
    pat_val = 8'hF1; pat_mask = 8'h01;
    run_gated(2'd0, 2'd0, 10, 1'b0, 4, '0, "R5");
    pat_en = 1'b0;
    // R4 infinite gate closed by stop
    run_gated(2'd0, 2'd3, 37, 1'b1, 3, '0, "R4");
    // R8 saturation: ch0 gives 1050 edges, reference passes 1023
    run_gated(2'd0, 2'd3, 2100, 1'b1, 2, '0, "R8");
    // R9 a restart discards the medium gate in progress
    mode = 2'd1; gsel = 2'd1;
    tick(prev_v, 1'b1, 1'b0, r);
    for (int k = 1; k <= 20; k++) tick(wave(k, 2), 1'b0, 1'b0, r);
    run_gated(2'd1, 2'd0, 10, 1'b0, 5, '0, "R9");
    idle(6);
    for (int i = 0; i < N; i++)
      chk(int'(edge_o[i*W +: W]) == last_e[i], "R9", $sformatf("held result ch%0d", i),
          edge_o[i*W +: W], last_e[i]);
    // R6 and R10 reciprocal with short gate, channels close at different clocks
    run_recip(2'd0, 10, 45, 0, 2, "R6");
    run_recip(2'd0, 10, 60, 0, 5, "R6");
    // R7 infinite reciprocal gate with a stop pulse
    run_recip(2'd3, 0, 60, 25, 4, "R7");
    idle(4);
    chk(sb.size() == 0, "R10", "results still owed", sb.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule